// File: doc/BRIEF.md
# Error-Tolerant Sync Word Detector

This block watches a recovered serial bit stream and raises a flag when the most recent bits resemble a programmed reference word. The reference word can be 8, 16, 24 or 32 bits long. A small number of bit errors can be tolerated: the flag is raised when the count of differing bits is at or below a limit of 0 to 3. Demodulation and clock recovery happen upstream. Each recovered bit arrives with a one-cycle strobe that stands for the rising edge of the recovered data clock.

The reference comes in as one word made of four bytes. The byte at the lowest register address is the first byte and sits in the most significant byte of the word. The detector works only while both its own enable and the upstream bit-synchronizer enable are high. While either one is low, the flag stays inactive, arriving bits are dropped and the fill count is cleared. The flag is active-high by default. A parameter can turn it into an active-low output.

Top module: `sync_word_detector`

## Requirements
- R1: During and right after reset, `match_o` sits at its inactive level: 0 for the default polarity, 1 when `ACTIVE_LOW` is set.
- R2: `len_sel` picks the window length: 0 gives 8 bits, 1 gives 16, 2 gives 24 and 3 gives 32. Bits received before the window have no effect on the result.
- R3: With `err_limit` = 0, the flag is raised only when every bit in the window equals the reference.
- R4: A window that differs from the reference in N bit positions raises the flag when N <= `err_limit`, and does not raise it when N = `err_limit` + 1.
- R5: While `detect_en` or `bitsync_en` is low, `match_o` becomes inactive on the next clock edge. Bits strobed during that time are dropped and do not enter the history.
- R6: The oldest bit of the window is compared with bit 7 of the first byte, which is `ref_word[31:24]`. The newest bit is compared with bit 0 of the last byte in use: `ref_word[31:24]`, `[23:16]`, `[15:8]` or `[7:0]` for lengths 8, 16, 24 or 32. Bytes beyond the window are ignored.
- R7: `match_o` changes only as a result of a `bit_valid` strobe. The output is registered and becomes visible after the clock edge that takes the bit in. It then holds until the next strobe, so a hit lasts one bit period.
- R8: After reset, and after the enables return high, no match is reported until at least the selected window length of bits has been taken in since then.
- R9: When `ACTIVE_LOW` is set, the output is the exact inverse of the default-polarity output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_valid | input | 1 | One-cycle strobe per recovered bit |
| bit_in | input | 1 | Recovered data bit |
| ref_word | input | 32 | Reference word; first byte in [31:24] |
| len_sel | input | 2 | Window length select (8 × (value+1) bits) |
| err_limit | input | 2 | Highest tolerated count of differing bits |
| detect_en | input | 1 | Detector enable |
| bitsync_en | input | 1 | Bit synchronizer enabled flag |
| match_o | output | 1 | Match flag, polarity set by ACTIVE_LOW |

## Verification
The bench feeds each reference byte in reversed bit order. A design that gets the MSB-first orientation wrong would report those reversed bytes as hits and miss the real ones. It builds windows with exactly `err_limit` and `err_limit`+1 flipped bits, so an off-by-one in the threshold compare shows up as a missed or spurious hit. It sends junk ahead of short windows to show that older history is masked out. It re-enables the detector with a history that already holds a full matching word, so a design that keeps its fill count across a disable would report a match too early. It also idles between strobes after a hit to catch a flag that decays or moves without a new bit.

// File: rtl/sd_pkg.sv
package sd_pkg;

    // Width of one reference byte / history group
    localparam int unsigned BYTE_W = 8;

    // Number of bits compared for a given length select value
    function automatic int unsigned window_bits(input int unsigned sel);
        return BYTE_W * (sel + 1);
    endfunction

endpackage

// File: rtl/sd_ref_align.sv
// Right-aligns the bytes in use of the reference word and builds the window mask.
module sd_ref_align
    import sd_pkg::*;
#(
    parameter  int unsigned NUM_BYTES = 4,
    localparam int unsigned HIST_W    = BYTE_W * NUM_BYTES,
    localparam int unsigned SEL_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic [HIST_W-1:0] ref_word,
    input  logic [SEL_W-1:0]  len_sel,
    output logic [HIST_W-1:0] ref_aligned,
    output logic [HIST_W-1:0] win_mask
);

    logic [NUM_BYTES-1:0][HIST_W-1:0] cand_ref;
    logic [NUM_BYTES-1:0][HIST_W-1:0] cand_mask;

    // One candidate per selectable length: first byte lands on the window top
    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_len
        localparam int unsigned SHIFT = BYTE_W * (NUM_BYTES - 1 - k);
        localparam int unsigned BITS  = BYTE_W * (k + 1);
        assign cand_ref[k]  = ref_word >> SHIFT;
        assign cand_mask[k] = {HIST_W{1'b1}} >> (HIST_W - BITS);
    end

    always_comb begin
        ref_aligned = '0;
        win_mask    = '0;
        if (int'(len_sel) < NUM_BYTES) begin
            win_mask    = cand_mask[len_sel];
            ref_aligned = cand_ref[len_sel] & cand_mask[len_sel];
        end
    end

endmodule

// File: rtl/sd_popcount.sv
// Counts set bits: per-byte partial sums, then a final sum.
module sd_popcount
    import sd_pkg::*;
#(
    parameter  int unsigned W      = 32,
    localparam int unsigned CW     = $clog2(W + 1),
    localparam int unsigned GROUPS = W / BYTE_W,
    localparam int unsigned GW     = $clog2(BYTE_W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);

    logic [GROUPS-1:0][GW-1:0] part;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic [GW-1:0] sum_g;
        always_comb begin
            sum_g = '0;
            for (int i = 0; i < BYTE_W; i++) begin
                sum_g = sum_g + GW'(vec[g*BYTE_W + i]);
            end
        end
        assign part[g] = sum_g;
    end

    always_comb begin
        count = '0;
        for (int g = 0; g < GROUPS; g++) begin
            count = count + CW'(part[g]);
        end
    end

endmodule

// File: rtl/sd_match_eval.sv
// Decides whether the candidate history is a hit.
module sd_match_eval
    import sd_pkg::*;
#(
    parameter  int unsigned NUM_BYTES = 4,
    parameter  int unsigned LIM_W     = 2,
    localparam int unsigned HIST_W    = BYTE_W * NUM_BYTES,
    localparam int unsigned SEL_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
    localparam int unsigned FILL_W    = $clog2(HIST_W + 1),
    localparam int unsigned CW        = $clog2(HIST_W + 1)
) (
    input  logic [HIST_W-1:0] hist_next,
    input  logic [HIST_W-1:0] ref_aligned,
    input  logic [HIST_W-1:0] win_mask,
    input  logic [SEL_W-1:0]  len_sel,
    input  logic [LIM_W-1:0]  err_limit,
    input  logic [FILL_W-1:0] fill_next,
    output logic              hit
);

    logic [HIST_W-1:0] diff;
    logic [CW-1:0]     err_cnt;
    logic [FILL_W-1:0] need;

    assign diff = (hist_next & win_mask) ^ ref_aligned;

    sd_popcount #(.W(HIST_W)) u_pop (
        .vec   (diff),
        .count (err_cnt)
    );

    always_comb begin
        need = FILL_W'(window_bits(32'(len_sel)));
        hit  = (fill_next >= need) && (err_cnt <= CW'(err_limit));
    end

endmodule

// File: rtl/sync_word_detector.sv
module sync_word_detector
    import sd_pkg::*;
#(
    parameter  int unsigned NUM_BYTES  = 4,
    parameter  int unsigned LIM_W      = 2,
    parameter  bit          ACTIVE_LOW = 1'b0,
    localparam int unsigned HIST_W     = BYTE_W * NUM_BYTES,
    localparam int unsigned SEL_W      = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
    localparam int unsigned FILL_W     = $clog2(HIST_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic [HIST_W-1:0] ref_word,
    input  logic [SEL_W-1:0]  len_sel,
    input  logic [LIM_W-1:0]  err_limit,
    input  logic              detect_en,
    input  logic              bitsync_en,
    output logic              match_o
);

    typedef struct packed {
        logic [HIST_W-1:0] hist;
        logic [FILL_W-1:0] fill;
        logic              match;
    } det_state_t;

    det_state_t st_d, st_q;

    logic              run;
    logic [HIST_W-1:0] hist_shift;
    logic [FILL_W-1:0] fill_inc;
    logic [HIST_W-1:0] ref_aligned;
    logic [HIST_W-1:0] win_mask;
    logic              hit;

    assign run        = detect_en & bitsync_en;
    assign hist_shift = {st_q.hist[HIST_W-2:0], bit_in};
    assign fill_inc   = (st_q.fill == FILL_W'(HIST_W)) ? st_q.fill : st_q.fill + 1'b1;

    sd_ref_align #(.NUM_BYTES(NUM_BYTES)) u_align (
        .ref_word    (ref_word),
        .len_sel     (len_sel),
        .ref_aligned (ref_aligned),
        .win_mask    (win_mask)
    );

    sd_match_eval #(.NUM_BYTES(NUM_BYTES), .LIM_W(LIM_W)) u_eval (
        .hist_next   (hist_shift),
        .ref_aligned (ref_aligned),
        .win_mask    (win_mask),
        .len_sel     (len_sel),
        .err_limit   (err_limit),
        .fill_next   (fill_inc),
        .hit         (hit)
    );

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.fill  = '0;
            st_d.match = 1'b0;
        end else if (bit_valid) begin
            st_d.hist  = hist_shift;
            st_d.fill  = fill_inc;
            st_d.match = hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign match_o = st_q.match ^ ACTIVE_LOW;

endmodule

// File: rtl/sd_chk.sv
module sd_chk
    import sd_pkg::*;
#(
    parameter  int unsigned NUM_BYTES  = 4,
    parameter  bit          ACTIVE_LOW = 1'b0,
    localparam int unsigned HIST_W     = BYTE_W * NUM_BYTES,
    localparam int unsigned SEL_W      = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
    localparam int unsigned CNT_W      = $clog2(HIST_W + 2) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_valid,
    input logic             detect_en,
    input logic             bitsync_en,
    input logic [SEL_W-1:0] len_sel,
    input logic             match_o
);

    logic             active;
    logic [CNT_W-1:0] seen_q;
    logic [CNT_W-1:0] need_q;

    assign active = match_o ^ ACTIVE_LOW;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
            need_q <= '0;
        end else if (!(detect_en && bitsync_en)) begin
            seen_q <= '0;
        end else if (bit_valid) begin
            if (seen_q != {CNT_W{1'b1}}) seen_q <= seen_q + 1'b1;
            need_q <= CNT_W'(window_bits(32'(len_sel)));
        end
    end

    // R5
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(detect_en && bitsync_en) |=> !active);

    // R7
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (detect_en && bitsync_en && !bit_valid) |=> $stable(match_o));

    // R7
    rise_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(bit_valid));

    // R8
    fill_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (seen_q >= need_q));

endmodule

bind sync_word_detector sd_chk #(
    .NUM_BYTES  (NUM_BYTES),
    .ACTIVE_LOW (ACTIVE_LOW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (bit_valid),
    .detect_en  (detect_en),
    .bitsync_en (bitsync_en),
    .len_sel    (len_sel),
    .match_o    (match_o)
);

// File: tb/sync_word_detector_bench.sv
module sync_word_detector_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bit_valid;
    logic        bit_in;
    logic [31:0] ref_word;
    logic [1:0]  len_sel;
    logic [1:0]  err_limit;
    logic        detect_en;
    logic        bitsync_en;
    logic        match_o;
    logic        match_lo;

    always #5 clk = ~clk;

    int          total = 0;
    int          bad   = 0;
    bit          pend  = 1'b0;
    bit          exp_q[$];
    string       tag_q[$];
    logic [31:0] m_hist = '0;
    int          m_fill = 0;

    sync_word_detector u_sync_word_detector (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .ref_word(ref_word), .len_sel(len_sel), .err_limit(err_limit),
        .detect_en(detect_en), .bitsync_en(bitsync_en), .match_o(match_o)
    );

    sync_word_detector #(.ACTIVE_LOW(1'b1)) u_lo (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .ref_word(ref_word), .len_sel(len_sel), .err_limit(err_limit),
        .detect_en(detect_en), .bitsync_en(bitsync_en), .match_o(match_lo)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model built from R2, R3, R4, R6 and R8
    function automatic bit model_hit();
        int          len_b = 8 * (int'(len_sel) + 1);
        logic [31:0] r     = ref_word >> (32 - len_b);
        int          diffs = 0;
        for (int i = 0; i < len_b; i++) if (m_hist[i] != r[i]) diffs++;
        return (m_fill >= len_b) && (diffs <= int'(err_limit));
    endfunction

    // Driver: one strobed bit, expected result pushed to the scoreboard
    task automatic send_bit(input logic b, input string tag);
        @(negedge clk);
        bit_valid = 1'b1;
        bit_in    = b;
        if (detect_en && bitsync_en) begin
            m_hist = {m_hist[30:0], b};
            if (m_fill < 32) m_fill++;
            exp_q.push_back(model_hit());
        end else begin
            exp_q.push_back(1'b0);
        end
        tag_q.push_back(tag);
        @(posedge clk);
        #1;
        bit_valid = 1'b0;
        pend      = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] v, input string tag);
        for (int i = 7; i >= 0; i--) send_bit(v[i], tag);
    endtask

    task automatic set_en(input logic d, input logic b);
        @(negedge clk);
        detect_en  = d;
        bitsync_en = b;
        if (!(d && b)) begin
            m_fill = 0;
            @(posedge clk);
            @(negedge clk);
            // R5: flag drops one edge after the gate closes
            check(match_o === 1'b0 && match_lo === 1'b1, "R5",
                  int'({match_lo, match_o}), 2);
        end
    endtask

    // R7: after a hit, flag holds across idle cycles
    task automatic idle_hold(input int n);
        logic v;
        bit   held = 1'b1;
        @(negedge clk);
        v = match_o;
        repeat (n) begin
            @(negedge clk);
            if (match_o !== v) held = 1'b0;
        end
        check(held && v === 1'b1, "R7", int'(match_o), 1);
    endtask

    // Monitor: compares outputs with scoreboard entries (R9 via inverted copy)
    initial begin
        forever begin
            @(negedge clk);
            if (pend) begin : mon
                bit    e;
                string t;
                pend = 1'b0;
                e    = exp_q.pop_front();
                t    = tag_q.pop_front();
                check(match_o === e && match_lo === ~e, t,
                      int'({match_lo, match_o}), int'({~e, e}));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        bit_valid  = 1'b0;
        bit_in     = 1'b0;
        ref_word   = {8'hB1, 8'h4E, 8'hD2, 8'h39};
        len_sel    = 2'd0;
        err_limit  = 2'd0;
        detect_en  = 1'b0;
        bitsync_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 and R9: reset levels of both polarities
        check(match_o === 1'b0 && match_lo === 1'b1, "R1",
              int'({match_lo, match_o}), 2);
        rst_n = 1'b1;

        set_en(1'b1, 1'b1);
        send_byte(8'hB1, "R8");      // first 7 bits blocked by fill count
        send_byte(8'h8D, "R6");      // bit-reversed first byte: no hit
        send_byte(8'hB1, "R3");
        idle_hold(5);
        send_bit(1'b0, "R7");        // next strobe moves the flag

        err_limit = 2'd1;
        send_byte(8'hB1 ^ 8'h10, "R4");
        send_byte(8'hB1 ^ 8'h11, "R4");
        err_limit = 2'd3;
        send_byte(8'hB1 ^ 8'h07, "R4");
        send_byte(8'hB1 ^ 8'h0F, "R4");

        err_limit = 2'd0;
        send_byte(8'hFF, "R2");
        send_byte(8'hB1, "R2");      // older junk masked out
        len_sel = 2'd1;
        send_byte(8'hB1, "R2");
        send_byte(8'h4E, "R2");
        len_sel = 2'd2;
        send_byte(8'hB1, "R2");
        send_byte(8'h4E, "R2");
        send_byte(8'hD2, "R2");
        len_sel = 2'd3;
        send_byte(8'hB1, "R6");
        send_byte(8'h4E, "R6");
        send_byte(8'hD2, "R6");
        send_byte(8'h39, "R6");

        set_en(1'b0, 1'b1);          // gate closes while a hit is showing
        send_byte(8'hB1, "R5");
        set_en(1'b1, 1'b0);
        send_byte(8'h4E, "R5");
        set_en(1'b1, 1'b1);
        send_byte(8'hB1, "R8");
        send_byte(8'h4E, "R8");
        set_en(1'b0, 1'b1);
        set_en(1'b1, 1'b1);
        send_byte(8'hD2, "R8");      // window holds full word, fill only 16
        send_byte(8'h39, "R8");
        send_byte(8'hB1, "R8");
        send_byte(8'h4E, "R8");
        send_byte(8'hD2, "R6");
        send_byte(8'h38, "R6");      // last bit differs, limit 0
        err_limit = 2'd1;
        send_byte(8'hB1, "R4");
        send_byte(8'h4E, "R4");
        send_byte(8'hD2, "R4");
        send_byte(8'h38, "R4");

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule